// File: doc/BRIEF.md
# Register Window Control Unit

This block tracks the windowed-register bookkeeping of a processor core that has `NWIN` register windows. It holds the current window pointer, four occupancy counters (windows free to save into, windows that can be restored, clean windows, and windows owned by another context), and a two-field trap-selection register. The core hands it one command per cycle: save, restore, return, or flush-windows. The core may instead issue a direct privileged write of the pointer, one counter, or the trap-selection register.

Each command updates the pointer and the counters at the clock edge. When a command cannot complete, the block raises a one-cycle trap request. The request carries a kind code (spill, fill, clean-window or misaligned return) and a 3-bit index taken from the trap-selection register. When a save or restore completes normally, the block also raises a destination-write enable, which tells the register file to write the result into the new window. All outputs are registered and are valid in the cycle after the command.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, free-to-save is NWIN-2, and restorable, clean, other and both trap-selection fields are 0. The trap request, destination-write enable and conflict flag are all 0.
- R2: Save (cmd 1) with free-to-save = 0 raises a spill trap and advances the pointer by two modulo NWIN, leaving the counters unchanged. The kind is 1 (spill-other) with the other-field index when the other counter is nonzero. Otherwise the kind is 0 (spill-normal) with the normal-field index.
- R3: Save with free-to-save nonzero and clean equal to restorable raises a clean-window trap (kind 4, index 0). It advances the pointer by one and leaves the counters unchanged.
- R4: Any other save advances the pointer by one, decrements free-to-save, increments restorable, and raises the destination-write enable without a trap.
- R5: Restore (cmd 2) always moves the pointer back by one modulo NWIN. With restorable = 0 it raises a fill trap: kind 3 with the other-field index if the other counter is nonzero, else kind 2 with the normal-field index. Otherwise it increments free-to-save, decrements restorable and raises the destination-write enable.
- R6: Pointer arithmetic wraps: +1 from NWIN-1 gives 0, +2 from NWIN-2 gives 0, and -1 from 0 gives NWIN-1.
- R7: Return (cmd 3) with either of the two target low bits set raises a misaligned trap (kind 5, index 0). The pointer and counters do not change.
- R8: Return with an aligned target behaves exactly as restore.
- R9: Flush-windows (cmd 4) raises a spill trap, selected as in R2, when free-to-save differs from NWIN-2. It leaves the pointer and counters unchanged in every case.
- R10: A privileged write (wr_en=1) is visible in the cycle after it is issued. The selectors are: 0 pointer, 1 free-to-save, 2 restorable, 3 clean, 4 other, 5 trap-selection (data[2:0] normal, data[5:3] other). Selectors 6 and 7 change nothing. A pointer value of NWIN or more is dropped.
- R11: A privileged write issued together with a command code 1 to 4 sets the conflict flag for one cycle. Neither the write nor the command is applied, and no trap is raised.
- R12: Command codes 0, 5, 6 and 7 with no write change nothing and raise nothing.
- R13: A trap request lasts one cycle per command and never coincides with the destination-write enable. The kind and index outputs are 0 whenever no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code (0 none, 1 save, 2 restore, 3 return, 4 flush) |
| tgt_lsb_i | input | 2 | Two low bits of the computed return target |
| wr_en_i | input | 1 | Privileged write strobe |
| wr_sel_i | input | 3 | Privileged write target selector |
| wr_data_i | input | WD_W | Privileged write value |
| cwp_o | output | CW | Current window pointer |
| cansave_o | output | CW | Free-to-save counter |
| canrestore_o | output | CW | Restorable counter |
| cleanwin_o | output | CW | Clean-window counter |
| otherwin_o | output | CW | Other-context counter |
| wst_normal_o | output | WS_W | Normal trap-selection field |
| wst_other_o | output | WS_W | Other trap-selection field |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_kind_o | output | 3 | Trap kind code |
| trap_idx_o | output | WS_W | Trap-selection index |
| dest_we_o | output | 1 | Destination write enable for a completed save or restore |
| conflict_o | output | 1 | Write and command issued in the same cycle |

## Verification
The bench sweeps every legal combination of free-to-save and restorable counts. For each one it runs two clean-counter settings, both values of the other counter, and all four commands, with the pointer placed so that wraps through 0 and NWIN-1 occur. A design that tested the clean condition before the spill condition would raise a clean trap where a spill is due. A design that held the pointer on a spill or fill trap would leave the pointer one or two windows short. A design that applied a misaligned return, or a write that collides with a command, would show counters that moved when they should have held. Choosing the wrong trap-selection field, or a flush test built on the wrong threshold, shows up as a wrong kind or index against the model.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

   typedef enum logic [2:0] {
      CMD_NONE    = 3'd0,
      CMD_SAVE    = 3'd1,
      CMD_RESTORE = 3'd2,
      CMD_RETURN  = 3'd3,
      CMD_FLUSH   = 3'd4
   } rw_cmd_e;

   typedef enum logic [2:0] {
      TK_SPILL_N = 3'd0,
      TK_SPILL_O = 3'd1,
      TK_FILL_N  = 3'd2,
      TK_FILL_O  = 3'd3,
      TK_CLEAN   = 3'd4,
      TK_ALIGN   = 3'd5
   } rw_trap_e;

   typedef enum logic [2:0] {
      SEL_PTR   = 3'd0,
      SEL_FREE  = 3'd1,
      SEL_REST  = 3'd2,
      SEL_CLEAN = 3'd3,
      SEL_OTHER = 3'd4,
      SEL_WST   = 3'd5
   } rw_sel_e;

   typedef enum logic [1:0] {
      MV_HOLD  = 2'd0,
      MV_INC1  = 2'd1,
      MV_INC2  = 2'd2,
      MV_DEC1  = 2'd3
   } rw_move_e;

   typedef enum logic [1:0] {
      CN_NONE    = 2'd0,
      CN_SAVE    = 2'd1,
      CN_RESTORE = 2'd2
   } rw_cnt_e;

endpackage

// File: rtl/rwin_ptr_step.sv
module rwin_ptr_step #(
   parameter int NWIN = 8,
   parameter int CW   = $clog2(NWIN)
) (
   input  logic [CW-1:0] cur_i,
   output logic [CW-1:0] inc1_o,
   output logic [CW-1:0] inc2_o,
   output logic [CW-1:0] dec1_o
);
   localparam bit POW2 = (NWIN == (1 << CW));

   generate
      if (POW2) begin : g_pow2
         // Natural wrap of a CW-bit counter is the modulo.
         assign inc1_o = cur_i + CW'(1);
         assign inc2_o = cur_i + CW'(2);
         assign dec1_o = cur_i - CW'(1);
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(NWIN - 1);
         localparam logic [CW-1:0] PENU = CW'(NWIN - 2);
         assign inc1_o = (cur_i == LAST) ? '0 : cur_i + CW'(1);
         assign inc2_o = (cur_i >= PENU) ? cur_i - PENU : cur_i + CW'(2);
         assign dec1_o = (cur_i == '0) ? LAST : cur_i - CW'(1);
      end
   endgenerate
endmodule

// File: rtl/rwin_decide.sv
module rwin_decide
   import rwin_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CW   = $clog2(NWIN),
   parameter int WS_W = 3
) (
   input  logic [2:0]      cmd_i,
   input  logic            misalign_i,
   input  logic [CW-1:0]   cansave_i,
   input  logic [CW-1:0]   canrestore_i,
   input  logic [CW-1:0]   cleanwin_i,
   input  logic [CW-1:0]   otherwin_i,
   input  logic [WS_W-1:0] wst_normal_i,
   input  logic [WS_W-1:0] wst_other_i,
   output logic            trap_o,
   output logic [2:0]      kind_o,
   output logic [WS_W-1:0] idx_o,
   output logic [1:0]      move_o,
   output logic [1:0]      cnt_o,
   output logic            we_o
);
   localparam logic [CW-1:0] FREE_MAX = CW'(NWIN - 2);

   logic            other_live;
   logic [WS_W-1:0] sel_idx;

   assign other_live = (otherwin_i != '0);
   assign sel_idx    = other_live ? wst_other_i : wst_normal_i;

   always_comb begin
      trap_o = 1'b0;
      kind_o = 3'd0;
      idx_o  = '0;
      move_o = MV_HOLD;
      cnt_o  = CN_NONE;
      we_o   = 1'b0;
      case (cmd_i)
         CMD_SAVE: begin
            if (cansave_i == '0) begin
               // Spill outranks clean-window.
               trap_o = 1'b1;
               kind_o = other_live ? TK_SPILL_O : TK_SPILL_N;
               idx_o  = sel_idx;
               move_o = MV_INC2;
            end else if (cleanwin_i == canrestore_i) begin
               trap_o = 1'b1;
               kind_o = TK_CLEAN;
               move_o = MV_INC1;
            end else begin
               move_o = MV_INC1;
               cnt_o  = CN_SAVE;
               we_o   = 1'b1;
            end
         end
         CMD_RESTORE, CMD_RETURN: begin
            if (cmd_i == CMD_RETURN && misalign_i) begin
               trap_o = 1'b1;
               kind_o = TK_ALIGN;
            end else begin
               move_o = MV_DEC1;
               if (canrestore_i == '0) begin
                  trap_o = 1'b1;
                  kind_o = other_live ? TK_FILL_O : TK_FILL_N;
                  idx_o  = sel_idx;
               end else begin
                  cnt_o = CN_RESTORE;
                  we_o  = 1'b1;
               end
            end
         end
         CMD_FLUSH: begin
            if (cansave_i != FREE_MAX) begin
               trap_o = 1'b1;
               kind_o = other_live ? TK_SPILL_O : TK_SPILL_N;
               idx_o  = sel_idx;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
   import rwin_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int WS_W = 3,
   parameter int WD_W = 8,
   localparam int CW  = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      cmd_i,
   input  logic [1:0]      tgt_lsb_i,
   input  logic            wr_en_i,
   input  logic [2:0]      wr_sel_i,
   input  logic [WD_W-1:0] wr_data_i,
   output logic [CW-1:0]   cwp_o,
   output logic [CW-1:0]   cansave_o,
   output logic [CW-1:0]   canrestore_o,
   output logic [CW-1:0]   cleanwin_o,
   output logic [CW-1:0]   otherwin_o,
   output logic [WS_W-1:0] wst_normal_o,
   output logic [WS_W-1:0] wst_other_o,
   output logic            trap_req_o,
   output logic [2:0]      trap_kind_o,
   output logic [WS_W-1:0] trap_idx_o,
   output logic            dest_we_o,
   output logic            conflict_o
);
   localparam logic [CW-1:0]   FREE_RST = CW'(NWIN - 2);
   localparam logic [WD_W-1:0] NWIN_D   = WD_W'(NWIN);

   generate
      if (NWIN < 3) begin : g_bad_nwin
         $error("rwin_ctrl: NWIN must be at least 3");
      end
      if (WD_W < 2 * WS_W || WD_W < CW) begin : g_bad_wd
         $error("rwin_ctrl: WD_W too narrow for the write targets");
      end
      if (WS_W < 1) begin : g_bad_ws
         $error("rwin_ctrl: WS_W must be positive");
      end
   endgenerate

   logic [CW-1:0]   cwp_q, cs_q, cr_q, cl_q, ow_q;
   logic [WS_W-1:0] wn_q, wo_q;
   logic            trap_q, we_q, conf_q;
   logic [2:0]      kind_q;
   logic [WS_W-1:0] idx_q;

   logic [CW-1:0]   inc1, inc2, dec1;
   logic            d_trap, d_we;
   logic [2:0]      d_kind;
   logic [WS_W-1:0] d_idx;
   logic [1:0]      d_move, d_cnt;
   logic            cmd_live, clash;

   rwin_ptr_step #(.NWIN(NWIN), .CW(CW)) u_step (
      .cur_i  (cwp_q),
      .inc1_o (inc1),
      .inc2_o (inc2),
      .dec1_o (dec1)
   );

   rwin_decide #(.NWIN(NWIN), .CW(CW), .WS_W(WS_W)) u_decide (
      .cmd_i        (cmd_i),
      .misalign_i   (tgt_lsb_i != 2'b00),
      .cansave_i    (cs_q),
      .canrestore_i (cr_q),
      .cleanwin_i   (cl_q),
      .otherwin_i   (ow_q),
      .wst_normal_i (wn_q),
      .wst_other_i  (wo_q),
      .trap_o       (d_trap),
      .kind_o       (d_kind),
      .idx_o        (d_idx),
      .move_o       (d_move),
      .cnt_o        (d_cnt),
      .we_o         (d_we)
   );

   assign cmd_live = (cmd_i >= CMD_SAVE) && (cmd_i <= CMD_FLUSH);
   assign clash    = wr_en_i && cmd_live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         cs_q   <= FREE_RST;
         cr_q   <= '0;
         cl_q   <= '0;
         ow_q   <= '0;
         wn_q   <= '0;
         wo_q   <= '0;
         trap_q <= 1'b0;
         kind_q <= 3'd0;
         idx_q  <= '0;
         we_q   <= 1'b0;
         conf_q <= 1'b0;
      end else begin
         trap_q <= 1'b0;
         kind_q <= 3'd0;
         idx_q  <= '0;
         we_q   <= 1'b0;
         conf_q <= clash;
         if (clash) begin
            // both requests dropped
         end else if (wr_en_i) begin
            case (wr_sel_i)
               SEL_PTR:   if (wr_data_i < NWIN_D) cwp_q <= wr_data_i[CW-1:0];
               SEL_FREE:  cs_q <= wr_data_i[CW-1:0];
               SEL_REST:  cr_q <= wr_data_i[CW-1:0];
               SEL_CLEAN: cl_q <= wr_data_i[CW-1:0];
               SEL_OTHER: ow_q <= wr_data_i[CW-1:0];
               SEL_WST: begin
                  wn_q <= wr_data_i[WS_W-1:0];
                  wo_q <= wr_data_i[2*WS_W-1:WS_W];
               end
               default: ;
            endcase
         end else begin
            trap_q <= d_trap;
            kind_q <= d_kind;
            idx_q  <= d_idx;
            we_q   <= d_we;
            case (d_move)
               MV_INC1: cwp_q <= inc1;
               MV_INC2: cwp_q <= inc2;
               MV_DEC1: cwp_q <= dec1;
               default: ;
            endcase
            case (d_cnt)
               CN_SAVE: begin
                  cs_q <= cs_q - CW'(1);
                  cr_q <= cr_q + CW'(1);
               end
               CN_RESTORE: begin
                  cs_q <= cs_q + CW'(1);
                  cr_q <= cr_q - CW'(1);
               end
               default: ;
            endcase
         end
      end
   end

   assign cwp_o        = cwp_q;
   assign cansave_o    = cs_q;
   assign canrestore_o = cr_q;
   assign cleanwin_o   = cl_q;
   assign otherwin_o   = ow_q;
   assign wst_normal_o = wn_q;
   assign wst_other_o  = wo_q;
   assign trap_req_o   = trap_q;
   assign trap_kind_o  = kind_q;
   assign trap_idx_o   = idx_q;
   assign dest_we_o    = we_q;
   assign conflict_o   = conf_q;

   AST_TRAP_NOT_WE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_o |-> !dest_we_o); // R13
   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req_o |-> (trap_kind_o == 3'd0 && trap_idx_o == '0)); // R13
   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cwp_o < CW'(NWIN - 1) || cwp_o == CW'(NWIN - 1)); // R10
   AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o |-> (cwp_o == $past(cwp_o) && cansave_o == $past(cansave_o)
                      && canrestore_o == $past(canrestore_o) && !trap_req_o)); // R11
   AST_MOVE_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      dest_we_o |-> ({1'b0, cansave_o} + {1'b0, canrestore_o}) ==
                    ($past({1'b0, cansave_o}) + $past({1'b0, canrestore_o}))); // R4
   AST_ALIGN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_o && trap_kind_o == TK_ALIGN) |->
      (cwp_o == $past(cwp_o) && canrestore_o == $past(canrestore_o)
       && cansave_o == $past(cansave_o))); // R7
endmodule

// File: tb/tb_rwin_ctrl.sv
module tb_rwin_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;

   typedef struct packed {
      logic [2:0] cwp, cs, cr, cl, ow, wn, wo;
      logic       trap;
      logic [2:0] kind, idx;
      logic       we, err;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [1:0] lsb = 2'd0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [2:0] cwp, cs, cr, cl, ow, wn, wo, kind, idx;
   logic       trap, we, err;

   int vectors = 0;
   int misses = 0;
   exp_t  exp_q[$];
   string tag_q[$];
   int m_cwp, m_cs, m_cr, m_cl, m_ow, m_wn, m_wo;

   always #(CLK_PERIOD/2) clk = ~clk;

   rwin_ctrl #(.NWIN(NW), .WS_W(3), .WD_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .tgt_lsb_i(lsb),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .cwp_o(cwp), .cansave_o(cs), .canrestore_o(cr), .cleanwin_o(cl),
      .otherwin_o(ow), .wst_normal_o(wn), .wst_other_o(wo),
      .trap_req_o(trap), .trap_kind_o(kind), .trap_idx_o(idx),
      .dest_we_o(we), .conflict_o(err)
   );

   function automatic exp_t snap();
      exp_t a;
      a.cwp = cwp; a.cs = cs; a.cr = cr; a.cl = cl; a.ow = ow;
      a.wn = wn; a.wo = wo; a.trap = trap; a.kind = kind; a.idx = idx;
      a.we = we; a.err = err;
      return a;
   endfunction

   function automatic exp_t model_state();
      exp_t e;
      e = '0;
      e.cwp = 3'(m_cwp); e.cs = 3'(m_cs); e.cr = 3'(m_cr); e.cl = 3'(m_cl);
      e.ow = 3'(m_ow); e.wn = 3'(m_wn); e.wo = 3'(m_wo);
      return e;
   endfunction

   // Monitor: compares each result one edge after its stimulus.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e, a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = snap();
         vectors++;
         if (a !== e) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
         end
      end
   end

   task automatic drive(input logic [2:0] c, input logic [1:0] l, input logic w,
                        input logic [2:0] s, input logic [7:0] d, input string force_tag);
      exp_t  e;
      string tag;
      int    old;
      int    kind_x = 0;
      int    idx_x = 0;
      bit    tr = 0;
      bit    wen = 0;
      bit    er = 0;
      @(negedge clk);
      cmd = c; lsb = l; wr_en = w; wr_sel = s; wr_data = d;
      old = m_cwp;
      tag = "R12";
      if (w && c >= 3'd1 && c <= 3'd4) begin
         er = 1; tag = "R11";
      end else if (w) begin
         tag = "R10";
         case (s)
            3'd0: if (d < 8'(NW)) m_cwp = int'(d);
            3'd1: m_cs = int'(d[2:0]);
            3'd2: m_cr = int'(d[2:0]);
            3'd3: m_cl = int'(d[2:0]);
            3'd4: m_ow = int'(d[2:0]);
            3'd5: begin m_wn = int'(d[2:0]); m_wo = int'(d[5:3]); end
            default: ;
         endcase
      end else if (c == 3'd1) begin
         if (m_cs == 0) begin
            tr = 1; kind_x = (m_ow != 0) ? 1 : 0; idx_x = (m_ow != 0) ? m_wo : m_wn;
            m_cwp = (m_cwp + 2) % NW; tag = "R2";
         end else if (m_cl == m_cr) begin
            tr = 1; kind_x = 4; m_cwp = (m_cwp + 1) % NW; tag = "R3";
         end else begin
            m_cwp = (m_cwp + 1) % NW; m_cs = (m_cs + 7) % 8; m_cr = (m_cr + 1) % 8;
            wen = 1; tag = "R4";
         end
         if (m_cwp < old) tag = {tag, "/R6"};
      end else if (c == 3'd2 || c == 3'd3) begin
         if (c == 3'd3 && l != 2'd0) begin
            tr = 1; kind_x = 5; tag = "R7";
         end else begin
            tag = (c == 3'd2) ? "R5" : "R8";
            m_cwp = (m_cwp + NW - 1) % NW;
            if (old == 0) tag = {tag, "/R6"};
            if (m_cr == 0) begin
               tr = 1; kind_x = (m_ow != 0) ? 3 : 2; idx_x = (m_ow != 0) ? m_wo : m_wn;
            end else begin
               m_cs = (m_cs + 1) % 8; m_cr = (m_cr + 7) % 8; wen = 1;
            end
         end
      end else if (c == 3'd4) begin
         tag = "R9";
         if (m_cs != NW - 2) begin
            tr = 1; kind_x = (m_ow != 0) ? 1 : 0; idx_x = (m_ow != 0) ? m_wo : m_wn;
         end
      end
      if (force_tag != "") tag = force_tag;
      e = model_state();
      e.trap = tr; e.kind = 3'(kind_x); e.idx = 3'(idx_x); e.we = wen; e.err = er;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [2:0] s, input int v);
      drive(3'd0, 2'd0, 1'b1, s, 8'(v), "");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      exp_t r;
      m_cwp = 0; m_cs = NW - 2; m_cr = 0; m_cl = 0; m_ow = 0; m_wn = 0; m_wo = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      r = model_state();
      vectors++;
      if (snap() !== r) begin
         misses++;
         $display("FAIL R1: actual %h expected %h", snap(), r);
      end

      // R12: idle and unused command codes
      drive(3'd0, 2'd0, 1'b0, 3'd0, 8'd0, "R12");
      drive(3'd6, 2'd0, 1'b0, 3'd0, 8'd0, "R12");
      drive(3'd7, 2'd3, 1'b0, 3'd0, 8'd0, "R12");
      // R10: pointer write out of range dropped, unused selectors
      wr(3'd0, 5);
      drive(3'd0, 2'd0, 1'b1, 3'd0, 8'd9, "R10");
      drive(3'd0, 2'd0, 1'b1, 3'd6, 8'hFF, "R10");
      // R11: write colliding with a command
      drive(3'd1, 2'd0, 1'b1, 3'd1, 8'd0, "R11");
      drive(3'd3, 2'd1, 1'b1, 3'd0, 8'd2, "R11");
      // trap-selection fields: normal 5, other 2
      wr(3'd5, (2 << 3) | 5);

      for (int a = 0; a <= NW - 2; a++) begin
         for (int b = 0; b <= NW - 2; b++) begin
            for (int o = 0; o < 2; o++) begin
               for (int k = 0; k < 2; k++) begin
                  for (int ci = 1; ci <= 4; ci++) begin
                     wr(3'd0, (a * 3 + b + o + ci) % NW);
                     wr(3'd1, a);
                     wr(3'd2, b);
                     wr(3'd3, (b + k) % 8);
                     wr(3'd4, o * 3);
                     drive(3'(ci), 2'((a + ci) % 4), 1'b0, 3'd0, 8'd0, "");
                  end
               end
            end
         end
      end

      // R6: explicit wraps at the edges
      wr(3'd0, NW - 1); wr(3'd1, 3); wr(3'd2, 1); wr(3'd3, 5);
      drive(3'd1, 2'd0, 1'b0, 3'd0, 8'd0, "R6");
      drive(3'd2, 2'd0, 1'b0, 3'd0, 8'd0, "R6");
      drive(3'd2, 2'd0, 1'b0, 3'd0, 8'd0, "R6");
      wr(3'd0, NW - 2); wr(3'd1, 0);
      drive(3'd1, 2'd0, 1'b0, 3'd0, 8'd0, "R6");
      // R13: trap drops after one cycle
      drive(3'd1, 2'd0, 1'b0, 3'd0, 8'd0, "R13");
      drive(3'd0, 2'd0, 1'b0, 3'd0, 8'd0, "R13");
      drive(3'd0, 2'd0, 1'b0, 3'd0, 8'd0, "R12");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule